// File: doc/BRIEF.md
# Serial EEPROM Bus Slave Controller

This block is the digital side of a 512-byte non-volatile memory that answers as a slave on a two-wire I2C bus. It oversamples SCL and SDA with the system clock and finds START and STOP conditions. It decodes a device address byte against two strap pins and keeps a 9-bit word pointer. It accepts single-byte writes and page writes of up to eight bytes, and it answers random and sequential reads. Written bytes wait in a page buffer. At STOP they are committed in one self-timed erase/write cycle. That cycle is counted either in system clocks or in rising edges of an external timing clock, picked by a select pin.

Every byte is stored as a 12-bit word: 8 data bits and 4 Hamming check bits, with parity bits at code positions 1, 2, 4 and 8. On read the decoder corrects any single flipped bit. The storage is modelled as a register array. A fault-mask input XORs into the stored word on its way to the decoder, so that bit errors can be injected.

The controller FSM has these states. `S_IDLE` waits for START. `S_DEV` shifts in the device byte. `S_DEV_ACK` acknowledges it, or drops to `S_IDLE` on a mismatch or while busy. After that ACK, a write goes to `S_ADR` and a read goes to `S_TX`. `S_ADR` is followed by `S_ADR_ACK` and then `S_WR`. `S_WR` and `S_WR_ACK` alternate for each data byte. `S_TX` shifts out one byte and then enters `S_MACK`. From `S_MACK` a master ACK returns to `S_TX` and a master NACK goes to `S_IDLE`. From any state, START goes to `S_DEV` and STOP goes to `S_IDLE`.

Top module: `seeprom_slave`

## Requirements
- R1: The device acknowledges a device byte only if bits [7:4] equal 4'b1010 and bits [3:2] equal `strap_i`. Any other byte gets no ACK (SDA stays released).
- R2: A write has three parts: a device byte with bit 0 = 0 and bit 1 = word-address bit 8, then a byte holding word-address bits [7:0], then one data byte. After STOP that byte is stored, and a later random read of the address returns it.
- R3: In a page write, each data byte goes to the current address. After each byte, address bits [2:0] increment and wrap inside the 8-byte page, and bits [8:3] stay fixed. Locations outside the page are unchanged.
- R4: While an erase/write cycle runs, the device does not acknowledge its own device byte. After the cycle ends it acknowledges again.
- R5: A read returns the byte at the current pointer, MSB first. Each master ACK advances the pointer by one, wrapping from 511 to 0. A master NACK ends the read. Read device bytes have bit 0 = 1, and their bit 1 is ignored.
- R6: Any single-bit error in the 12-bit stored word, injected through `fault_mask_i`, is corrected on read.
- R7: With `tsel_i` = 0 the cycle lasts INT_CYCLES system clocks. With `tsel_i` = 1 it lasts EXT_TICKS rising edges of `tclk_i`, and it never ends while `tclk_i` is still.
- R8: A repeated START discards buffered write data. A STOP with no data byte since the address starts no erase/write cycle.
- R9: After reset SDA is released and no cycle is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 2 | Device-select strap pins |
| tsel_i | input | 1 | 1 times the write cycle from `tclk_i` |
| tclk_i | input | 1 | External write-timing clock |
| fault_mask_i | input | 12 | XOR mask applied to the stored word on read |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except to form START and STOP. They also assume that each SCL phase lasts several system clocks, so that the synchronizers see every edge, and that STOP never comes while the slave is pulling SDA low. The bench master drives SCL with quarter periods of eight clocks and moves SDA only in the low phase. It releases SDA for every bit the slave may drive, and it issues STOP only after a full byte and its acknowledge.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
    localparam int AW = 9;
    localparam int CW = 12;

    typedef enum logic [3:0] {
        S_IDLE, S_DEV, S_DEV_ACK, S_ADR, S_ADR_ACK,
        S_WR, S_WR_ACK, S_TX, S_MACK
    } st_e;

    function automatic logic [CW-1:0] sec_encode(input logic [7:0] d);
        logic [12:1] w;
        logic        par;
        int          k;
        w = '0;
        k = 0;
        for (int p = 1; p <= 12; p++) begin
            if ((p & (p - 1)) != 0) begin
                w[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < 4; b++) begin
            par = 1'b0;
            for (int p = 1; p <= 12; p++)
                if (((p >> b) & 1) == 1) par ^= w[p];
            w[1 << b] = par;
        end
        return w;
    endfunction

    function automatic logic [7:0] sec_decode(input logic [CW-1:0] c);
        logic [12:1] w;
        logic [3:0]  syn;
        logic [7:0]  d;
        int          k;
        w   = c;
        syn = '0;
        d   = '0;
        for (int p = 1; p <= 12; p++)
            if (w[p]) syn ^= 4'(p);
        if (syn != 4'd0 && syn <= 4'd12) w[syn] = ~w[syn];
        k = 0;
        for (int p = 1; p <= 12; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[k] = w[p];
                k++;
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/seeprom_timer.sv
module seeprom_timer #(
    parameter int INT_CYCLES = 2000,
    parameter int EXT_TICKS  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ext_sel,
    input  logic ext_clk,
    output logic busy,
    output logic done
);
    localparam int LIM = (INT_CYCLES > EXT_TICKS) ? INT_CYCLES : EXT_TICKS;
    localparam int CNW = $clog2(LIM + 1);

    logic [2:0]     ext_q;
    logic           use_ext;
    logic [CNW-1:0] cnt;
    logic           tick, last;

    assign tick = use_ext ? (ext_q[1] & ~ext_q[2]) : 1'b1;
    assign last = use_ext ? (cnt == CNW'(EXT_TICKS - 1)) : (cnt == CNW'(INT_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q   <= '0;
            use_ext <= 1'b0;
            cnt     <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            ext_q <= {ext_q[1:0], ext_clk};
            done  <= 1'b0;
            if (start && !busy) begin
                busy    <= 1'b1;
                use_ext <= ext_sel;
                cnt     <= '0;
            end else if (busy && tick) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        p_start_idle_r7: assert property (disable iff (!rst_n) start |-> !busy);
        p_done_after_busy_r7: assert property (disable iff (!rst_n)
            done |-> ($past(busy) && !busy));
    end
endmodule

// File: rtl/seeprom_array.sv
module seeprom_array
    import seeprom_pkg::*;
#(
    parameter int PB = 3
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [AW-PB-1:0]      wr_page,
    input  logic [(1<<PB)-1:0]    wr_mask,
    input  logic [(1<<PB)-1:0][7:0] wr_data,
    input  logic [AW-1:0]         rd_addr,
    input  logic [CW-1:0]         fault_mask,
    output logic [7:0]            rd_data
);
    localparam int DEPTH = 1 << AW;
    localparam int PAGE  = 1 << PB;

    logic [CW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < PAGE; i++)
                if (wr_mask[i]) mem[{wr_page, PB'(i)}] <= sec_encode(wr_data[i]);
        end
    end

    assign rd_data = sec_decode(mem[rd_addr] ^ fault_mask);
endmodule

// File: rtl/seeprom_slave.sv
module seeprom_slave
    import seeprom_pkg::*;
#(
    parameter int INT_CYCLES = 2000,
    parameter int EXT_TICKS  = 16,
    parameter int PB         = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic [1:0]  strap_i,
    input  logic        tsel_i,
    input  logic        tclk_i,
    input  logic [11:0] fault_mask_i
);
    localparam int PAGE = 1 << PB;

    st_e                      state, nxt;
    logic [2:0]               scl_q, sda_q;
    logic                     scl_rise, scl_fall, start_c, stop_c, sda_s;
    logic [2:0]               bcnt;
    logic                     ph, ack_ok, rw, a8;
    logic [7:0]               shreg, tx, rx_byte, rd_byte;
    logic [AW-1:0]            addr;
    logic [PAGE-1:0][7:0]     pbuf;
    logic [PAGE-1:0]          pmask;
    logic                     tmr_start, tmr_busy, tmr_done;

    assign sda_s    = sda_q[1];
    assign scl_rise = scl_q[1] & ~scl_q[2];
    assign scl_fall = ~scl_q[1] & scl_q[2];
    assign start_c  = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
    assign stop_c   = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];
    assign rx_byte  = {shreg[6:0], sda_s};
    assign tmr_start = stop_c && (pmask != '0) && !tmr_busy;

    seeprom_timer #(.INT_CYCLES(INT_CYCLES), .EXT_TICKS(EXT_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .ext_sel(tsel_i),
        .ext_clk(tclk_i), .busy(tmr_busy), .done(tmr_done)
    );

    seeprom_array #(.PB(PB)) u_array (
        .clk(clk), .wr_en(tmr_done), .wr_page(addr[AW-1:PB]), .wr_mask(pmask),
        .wr_data(pbuf), .rd_addr(addr), .fault_mask(fault_mask_i), .rd_data(rd_byte)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_c) nxt = S_DEV;
        else if (stop_c) nxt = S_IDLE;
        else begin
            unique case (state)
                S_IDLE:    nxt = S_IDLE;
                S_DEV:     if (scl_rise && bcnt == 3'd7) nxt = S_DEV_ACK;
                S_DEV_ACK: if (scl_fall) begin
                               if (!ph) nxt = ack_ok ? S_DEV_ACK : S_IDLE;
                               else     nxt = rw ? S_TX : S_ADR;
                           end
                S_ADR:     if (scl_rise && bcnt == 3'd7) nxt = S_ADR_ACK;
                S_ADR_ACK: if (scl_fall && ph) nxt = S_WR;
                S_WR:      if (scl_rise && bcnt == 3'd7) nxt = S_WR_ACK;
                S_WR_ACK:  if (scl_fall && ph) nxt = S_WR;
                S_TX:      if (scl_fall && bcnt == 3'd7) nxt = S_MACK;
                S_MACK:    if (scl_rise && sda_s) nxt = S_IDLE;
                           else if (scl_fall) nxt = S_TX;
                default:   nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 3'b111; sda_q <= 3'b111;
            bcnt <= '0; ph <= 1'b0; ack_ok <= 1'b0; rw <= 1'b0; a8 <= 1'b0;
            shreg <= '0; tx <= '0; addr <= '0; pbuf <= '0; pmask <= '0;
            sda_oe_o <= 1'b0;
        end else begin
            scl_q <= {scl_q[1:0], scl_i};
            sda_q <= {sda_q[1:0], sda_i};
            if (tmr_done) pmask <= '0;
            if (start_c) begin
                bcnt <= '0; ph <= 1'b0; sda_oe_o <= 1'b0;
                if (!tmr_busy) pmask <= '0;
            end else if (stop_c) begin
                sda_oe_o <= 1'b0;
            end else begin
                unique case (state)
                    S_IDLE: ;
                    S_DEV, S_ADR, S_WR: if (scl_rise) begin
                        shreg <= rx_byte;
                        bcnt  <= bcnt + 1'b1;
                        ph    <= 1'b0;
                        if (bcnt == 3'd7) begin
                            if (state == S_DEV) begin
                                ack_ok <= (rx_byte[7:4] == 4'b1010) &&
                                          (rx_byte[3:2] == strap_i) && !tmr_busy;
                                rw <= rx_byte[0];
                                a8 <= rx_byte[1];
                            end else if (state == S_ADR) begin
                                addr <= {a8, rx_byte};
                            end else begin
                                pbuf[addr[PB-1:0]]  <= rx_byte;
                                pmask[addr[PB-1:0]] <= 1'b1;
                                addr <= {addr[AW-1:PB], addr[PB-1:0] + 1'b1};
                            end
                        end
                    end
                    S_DEV_ACK, S_ADR_ACK, S_WR_ACK: if (scl_fall) begin
                        if (!ph) begin
                            ph <= 1'b1;
                            sda_oe_o <= (state != S_DEV_ACK) || ack_ok;
                        end else begin
                            ph <= 1'b0;
                            bcnt <= '0;
                            if (state == S_DEV_ACK && rw) begin
                                tx <= rd_byte;
                                sda_oe_o <= ~rd_byte[7];
                            end else begin
                                sda_oe_o <= 1'b0;
                            end
                        end
                    end
                    S_TX: if (scl_fall) begin
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == 3'd7) sda_oe_o <= 1'b0;
                        else begin
                            tx <= {tx[6:0], 1'b0};
                            sda_oe_o <= ~tx[6];
                        end
                    end
                    S_MACK: begin
                        if (scl_rise && !sda_s) addr <= addr + 1'b1;
                        if (scl_fall) begin
                            tx <= rd_byte;
                            sda_oe_o <= ~rd_byte[7];
                            bcnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        p_busy_nack_r4: assert property (disable iff (!rst_n)
            (state == S_DEV_ACK && tmr_busy) |-> !sda_oe_o);
        p_addr_wrap_r5: assert property (disable iff (!rst_n)
            ($past(state) == S_MACK && $past(addr) == {AW{1'b1}} && addr != $past(addr))
            |-> addr == '0);
        p_idle_release_r9: assert property (disable iff (!rst_n)
            (state == S_IDLE && $past(state) == S_IDLE) |-> !sda_oe_o);
    end
endmodule

// File: tb/test_seeprom_slave.sv
module test_seeprom_slave;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic        tsel = 1'b0;
    logic        tclk = 1'b0;
    logic        ext_run = 1'b0;
    logic [11:0] fmask = '0;
    logic [1:0]  strap = 2'b10;
    logic        sda_oe;
    wire         sda_bus = ~(m_low | sda_oe);

    int          vectors = 0;
    int          errors = 0;
    logic        finished = 1'b0;
    logic [7:0]  rbuf [16];
    logic [7:0]  wbuf [8];

    always #2.5 clk = ~clk;
    always #200 if (ext_run) tclk = ~tclk;

    seeprom_slave #(.INT_CYCLES(2000), .EXT_TICKS(16)) i_seeprom_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .strap_i(strap), .tsel_i(tsel), .tclk_i(tclk), .fault_mask_i(fmask)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic qw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_low = 1'b0; qw(Q); scl = 1'b1; qw(Q); m_low = 1'b1; qw(Q); scl = 1'b0; qw(Q);
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; qw(Q); scl = 1'b1; qw(Q); m_low = 1'b0; qw(Q);
    endtask

    task automatic put_bit(input logic b);
        m_low = ~b; qw(Q); scl = 1'b1; qw(2 * Q); scl = 1'b0; qw(Q);
    endtask

    task automatic get_bit(output logic b);
        m_low = 1'b0; qw(Q); scl = 1'b1; qw(Q); b = sda_bus; qw(Q); scl = 1'b0; qw(Q);
    endtask

    task automatic byte_out(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic byte_in(input logic ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~ack);
    endtask

    function automatic logic [7:0] devb(input logic [8:0] a, input logic rd);
        return {4'b1010, strap, a[8], rd};
    endfunction

    task automatic write_seq(input logic [8:0] a, input int n);
        logic ack;
        i2c_start();
        byte_out(devb(a, 1'b0), ack);
        byte_out(a[7:0], ack);
        for (int i = 0; i < n; i++) byte_out(wbuf[i], ack);
        i2c_stop();
    endtask

    task automatic wait_ready(output logic ok);
        logic ack;
        ok = 1'b0;
        for (int t = 0; t < 60 && !ok; t++) begin
            i2c_start();
            byte_out(devb(9'd0, 1'b0), ack);
            i2c_stop();
            ok = ack;
        end
    endtask

    task automatic read_seq(input logic [8:0] a, input int n);
        logic ack;
        logic [7:0] d;
        i2c_start();
        byte_out(devb(a, 1'b0), ack);
        byte_out(a[7:0], ack);
        i2c_start();
        byte_out(devb(9'd0, 1'b1), ack);
        for (int i = 0; i < n; i++) begin
            byte_in(i != n - 1, d);
            rbuf[i] = d;
        end
        i2c_stop();
    endtask

    task automatic t_reset();
        qw(10);
        check(sda_oe == 1'b0, "R9 sda released after reset", int'(sda_oe), 0);
    endtask

    task automatic t_devaddr();
        logic ack;
        i2c_start(); byte_out({4'b1010, 2'b01, 2'b00}, ack); i2c_stop();
        check(!ack, "R1 wrong strap bits", int'(ack), 0);
        i2c_start(); byte_out({4'b1011, strap, 2'b00}, ack); i2c_stop();
        check(!ack, "R1 wrong fixed prefix", int'(ack), 0);
        i2c_start(); byte_out(devb(9'd0, 1'b0), ack); i2c_stop();
        check(ack, "R1 matching device byte", int'(ack), 1);
    endtask

    task automatic t_byte_write();
        logic ack, ok;
        wbuf[0] = 8'hEE; write_seq(9'h010, 1); wait_ready(ok);
        wbuf[0] = 8'h3C; write_seq(9'h1A5, 1);
        i2c_start(); byte_out(devb(9'd0, 1'b0), ack); i2c_stop();
        check(!ack, "R4 no ack while cycle runs", int'(ack), 0);
        wait_ready(ok);
        check(ok, "R4 ack after cycle ends", int'(ok), 1);
        read_seq(9'h1A5, 1);
        check(rbuf[0] == 8'h3C, "R2 byte write readback", int'(rbuf[0]), 'h3C);
    endtask

    task automatic t_page();
        logic ok;
        logic [7:0] exp [9];
        for (int i = 0; i < 8; i++) wbuf[i] = 8'h10 + 8'(i);
        write_seq(9'h00D, 8);
        wait_ready(ok);
        for (int k = 0; k < 8; k++) exp[k] = 8'h10 + 8'((k - 5 + 8) % 8);
        exp[8] = 8'hEE;
        read_seq(9'h008, 9);
        for (int k = 0; k < 8; k++)
            check(rbuf[k] == exp[k], "R3 page wrap content", int'(rbuf[k]), int'(exp[k]));
        check(rbuf[8] == exp[8], "R3 next page untouched", int'(rbuf[8]), int'(exp[8]));
    endtask

    task automatic t_wrap();
        logic ok;
        wbuf[0] = 8'hA1; write_seq(9'h1FF, 1); wait_ready(ok);
        wbuf[0] = 8'h5B; write_seq(9'h000, 1); wait_ready(ok);
        read_seq(9'h1FF, 2);
        check(rbuf[0] == 8'hA1, "R5 read at 511", int'(rbuf[0]), 'hA1);
        check(rbuf[1] == 8'h5B, "R5 wrap to 0", int'(rbuf[1]), 'h5B);
    endtask

    task automatic t_ecc();
        for (int b = 0; b < 12; b++) begin
            fmask = 12'(1) << b;
            read_seq(9'h1A5, 1);
            check(rbuf[0] == 8'h3C, "R6 single bit corrected", int'(rbuf[0]), 'h3C);
        end
        fmask = '0;
    endtask

    task automatic t_discard();
        logic ack;
        i2c_start(); byte_out(devb(9'h1FF, 1'b0), ack); byte_out(8'hFF, ack); i2c_stop();
        i2c_start(); byte_out(devb(9'd0, 1'b0), ack); i2c_stop();
        check(ack, "R8 address-only write starts no cycle", int'(ack), 1);
        i2c_start(); byte_out(devb(9'h1A5, 1'b0), ack); byte_out(8'hA5, ack);
        byte_out(8'h99, ack);
        i2c_start(); i2c_stop();
        i2c_start(); byte_out(devb(9'd0, 1'b0), ack); i2c_stop();
        check(ack, "R8 repeated start drops data", int'(ack), 1);
        read_seq(9'h1A5, 1);
        check(rbuf[0] == 8'h3C, "R8 location keeps old value", int'(rbuf[0]), 'h3C);
    endtask

    task automatic t_ext();
        logic ack, ok;
        tsel = 1'b1;
        wbuf[0] = 8'h77; write_seq(9'h0A5, 1);
        qw(3000);
        i2c_start(); byte_out(devb(9'd0, 1'b0), ack); i2c_stop();
        check(!ack, "R7 busy while timing clock still", int'(ack), 0);
        ext_run = 1'b1;
        wait_ready(ok);
        check(ok, "R7 cycle ends on timing clock", int'(ok), 1);
        ext_run = 1'b0;
        tsel = 1'b0;
        read_seq(9'h0A5, 1);
        check(rbuf[0] == 8'h77, "R7 data committed", int'(rbuf[0]), 'h77);
    endtask

    initial begin
        qw(5);
        rst_n = 1'b1;
        t_reset();
        t_devaddr();
        t_byte_write();
        t_page();
        t_wrap();
        t_ecc();
        t_discard();
        t_ext();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule